// File: doc/BRIEF.md
# Trigger Throttle with Buffer-Occupancy Emulation

This block sits between a first-level trigger source and the front-end readout of a detector. It runs on the bunch-crossing clock. On each cycle it decides whether a raw trigger pulse may become an accepted trigger. It refuses a trigger in three cases: the front-end event buffer would overflow, the trigger arrives too soon after the previous accept, or too many triggers have already been accepted in a recent stretch of time. The front-end buffer itself is not part of the block. Its fill level is copied by a local counter that empties at a fixed readout time per event. That readout time is 36 cycles by default, which is 900 ns at 40 MHz. With this setting the sustained accept rate settles near 1 MHz.

The occupancy model is a three-state machine. In EMPTY no readout runs. In DRAIN a readout timer runs and at least one free slot remains. In FULL all slots are taken. The transitions are as follows. EMPTY goes to DRAIN on an accept. DRAIN goes to FULL on an accept with no slot release when one slot is left. DRAIN goes to EMPTY on a slot release with no accept when one event is left. FULL goes to DRAIN on a slot release with no accept. In every other case the state is held.

The busy output is raised by the throttle itself. It clears only when the condition that caused it goes away. A saturating counter records the number of refused triggers.

Top module: `trig_throttle`

## Requirements
- R1: After reset, accept, busy, occupancy and rej_count are all 0.
- R2: accept is high in the same cycle as trig_in exactly when no blocking rule applies. It is never high without trig_in.
- R3: Each accept adds one event to occupancy in the next cycle. Occupancy never exceeds DEPTH (16). A trigger that arrives while all DEPTH slots are taken is refused.
- R4: Each event is read out for READOUT_CYC (36) cycles. Readout of the oldest event starts on the cycle after it is accepted into an empty model. Readouts follow each other with no idle cycle. Occupancy drops by one on the cycle after a readout completes.
- R5: A trigger that arrives in the same cycle as a readout completion sees the released slot. It is accepted when the model is full, and occupancy then stays at DEPTH.
- R6: After an accept in cycle t, no trigger is accepted before cycle t+min_gap. A min_gap of 0 or 1 imposes no spacing.
- R7: A trigger in cycle t is refused when win_max or more accepts fall in cycles t-win_len to t-1. A win_len of 0 turns this rule off. win_len is capped at WIN_LEN_MAX (64).
- R8: busy is the OR of three conditions: the model is full and no slot is released this cycle, the spacing hold is active, or the window limit is reached.
- R9: rej_count increments on each refused trigger and saturates at all ones. rej_clr sets it to 0 on the next edge and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Raw trigger pulse, one cycle per trigger |
| min_gap | input | GAP_W | Minimum cycles between accepts |
| win_len | input | WIN_W | Sliding window length in cycles |
| win_max | input | WIN_W | Maximum accepts per window |
| rej_clr | input | 1 | Synchronous clear of the refused-trigger count |
| accept | output | 1 | Accepted trigger, same cycle as trig_in |
| busy | output | 1 | Throttle is refusing triggers this cycle |
| occupancy | output | OCC_W | Emulated buffer fill level |
| rej_count | output | REJ_W | Saturating count of refused triggers |

## Verification
The first stimulus is a trigger held high on every cycle with only spacing enabled. This gives one accept every min_gap cycles and separates an off-by-one in the hold count from a correct hold. The same continuous trigger with all rate rules off fills the model to 16. After that, accepts can happen only on slot-release cycles, which shows whether a same-cycle release is honoured and whether the drain runs back-to-back. A long idle stretch then shows the 36-cycle readout per event. A continuous trigger under a tight window limit shows where the window edge lies, one cycle early or late. A long random trigger stream with occasional clears mixes all the rules against a behavioural model, and the rejects there drive the narrow count into saturation.

// File: rtl/thr_pkg.sv
`timescale 1ns/1ps
package thr_pkg;
    typedef enum logic [1:0] {
        EMU_EMPTY = 2'd0,
        EMU_DRAIN = 2'd1,
        EMU_FULL  = 2'd2
    } emu_state_e;
endpackage

// File: rtl/derand_emu.sv
`timescale 1ns/1ps
module derand_emu
    import thr_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int READOUT_CYC = 36,
    localparam int OCC_W      = $clog2(DEPTH + 1),
    localparam int TMR_W      = $clog2(READOUT_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    output logic [OCC_W-1:0] occ,
    output logic             pop,
    output logic             full_blk
);
    emu_state_e       st, st_nx;
    logic [OCC_W-1:0] occ_q;
    logic [TMR_W-1:0] tmr;
    logic             tmr_done;

    assign tmr_done = (tmr == TMR_W'(READOUT_CYC - 1));
    assign occ      = occ_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= EMU_EMPTY;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            EMU_EMPTY: if (push) st_nx = EMU_DRAIN;
            EMU_DRAIN: begin
                if (push && !pop && occ_q == OCC_W'(DEPTH - 1)) st_nx = EMU_FULL;
                else if (pop && !push && occ_q == OCC_W'(1))    st_nx = EMU_EMPTY;
            end
            EMU_FULL:  if (pop && !push) st_nx = EMU_DRAIN;
            default:   st_nx = EMU_EMPTY;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        pop      = 1'b0;
        full_blk = 1'b0;
        unique case (st)
            EMU_EMPTY: ;
            EMU_DRAIN: pop = tmr_done;
            EMU_FULL: begin
                pop      = tmr_done;
                full_blk = !tmr_done;
            end
            default: ;
        endcase
    end

    // Fill level and readout timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
            tmr   <= '0;
        end else begin
            occ_q <= occ_q + OCC_W'(push) - OCC_W'(pop);
            if (st == EMU_EMPTY || pop) tmr <= '0;
            else                        tmr <= tmr + TMR_W'(1);
        end
    end
endmodule

// File: rtl/gap_timer.sv
`timescale 1ns/1ps
module gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [GAP_W-1:0] min_gap,
    output logic             hold
);
    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (fire)           cnt <= (min_gap == '0) ? '0 : min_gap - GAP_W'(1);
        else if (cnt != '0)      cnt <= cnt - GAP_W'(1);
    end

    assign hold = (cnt != '0);
endmodule

// File: rtl/rate_window.sv
`timescale 1ns/1ps
module rate_window #(
    parameter int WIN_LEN_MAX = 64,
    localparam int WIN_W      = $clog2(WIN_LEN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [WIN_W-1:0] win_len,
    input  logic [WIN_W-1:0] win_max,
    output logic             limit
);
    logic [WIN_LEN_MAX-1:0] hist;
    logic [WIN_W-1:0]       cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[WIN_LEN_MAX-2:0], fire};
    end

    always_comb begin
        cnt = '0;
        for (int i = 0; i < WIN_LEN_MAX; i++) begin
            if (i < int'(win_len) && hist[i]) cnt = cnt + WIN_W'(1);
        end
    end

    assign limit = (win_len != '0) && (cnt >= win_max);
endmodule

// File: rtl/trig_throttle.sv
`timescale 1ns/1ps
module trig_throttle #(
    parameter int DEPTH       = 16,
    parameter int READOUT_CYC = 36,
    parameter int GAP_W       = 8,
    parameter int WIN_LEN_MAX = 64,
    parameter int REJ_W       = 16,
    localparam int OCC_W      = $clog2(DEPTH + 1),
    localparam int WIN_W      = $clog2(WIN_LEN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [GAP_W-1:0] min_gap,
    input  logic [WIN_W-1:0] win_len,
    input  logic [WIN_W-1:0] win_max,
    input  logic             rej_clr,
    output logic             accept,
    output logic             busy,
    output logic [OCC_W-1:0] occupancy,
    output logic [REJ_W-1:0] rej_count
);
    logic full_blk, slot_pop, gap_hold, win_limit;

    derand_emu #(.DEPTH(DEPTH), .READOUT_CYC(READOUT_CYC)) u_emu (
        .clk(clk), .rst_n(rst_n), .push(accept),
        .occ(occupancy), .pop(slot_pop), .full_blk(full_blk)
    );

    gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .fire(accept),
        .min_gap(min_gap), .hold(gap_hold)
    );

    rate_window #(.WIN_LEN_MAX(WIN_LEN_MAX)) u_win (
        .clk(clk), .rst_n(rst_n), .fire(accept),
        .win_len(win_len), .win_max(win_max), .limit(win_limit)
    );

    assign busy   = full_blk | gap_hold | win_limit;
    assign accept = trig_in & ~busy;

    always_ff @(posedge clk) begin
        if (!rst_n || rej_clr)
            rej_count <= '0;
        else if (trig_in && !accept && rej_count != '1)
            rej_count <= rej_count + REJ_W'(1);
    end
endmodule

// File: rtl/throttle_chk.sv
`timescale 1ns/1ps
module throttle_chk #(
    parameter int DEPTH = 16,
    parameter int GAP_W = 8,
    parameter int OCC_W = 5,
    parameter int REJ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_in,
    input logic             accept,
    input logic             busy,
    input logic             rej_clr,
    input logic [GAP_W-1:0] min_gap,
    input logic [OCC_W-1:0] occupancy,
    input logic [REJ_W-1:0] rej_count
);
    assert_only_on_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> trig_in);

    assert_bounded_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= OCC_W'(DEPTH));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (occupancy == $past(occupancy) ||
                  occupancy == $past(occupancy) + OCC_W'(1) ||
                  occupancy + OCC_W'(1) == $past(occupancy)));

    assert_empty_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && occupancy == '0) |=> occupancy == '0);

    assert_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && min_gap > GAP_W'(1)) |=> !accept);

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !busy);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rej_clr |=> rej_count == '0);
endmodule

bind trig_throttle throttle_chk #(
    .DEPTH(DEPTH), .GAP_W(GAP_W), .OCC_W(OCC_W), .REJ_W(REJ_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .accept(accept),
    .busy(busy), .rej_clr(rej_clr), .min_gap(min_gap),
    .occupancy(occupancy), .rej_count(rej_count)
);

// File: tb/tb_trig_throttle.sv
`timescale 1ns/1ps
module tb_trig_throttle;
    localparam int DEPTH = 16;
    localparam int RD    = 36;
    localparam int REJ_W = 6;
    localparam int REJ_MAX = (1 << REJ_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_in = 1'b0;
    logic [7:0] min_gap = '0;
    logic [6:0] win_len = '0;
    logic [6:0] win_max = '0;
    logic       rej_clr = 1'b0;
    logic       accept, busy;
    logic [4:0] occupancy;
    logic [REJ_W-1:0] rej_count;

    always #10 clk = ~clk;

    trig_throttle #(.REJ_W(REJ_W)) dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .min_gap(min_gap),
        .win_len(win_len), .win_max(win_max), .rej_clr(rej_clr),
        .accept(accept), .busy(busy), .occupancy(occupancy), .rej_count(rej_count)
    );

    int checks = 0;
    int bad = 0;
    string phase = "R1 reset";

    // Behavioural reference state
    int cyc = 0;
    int m_occ = 0;
    int m_tmr = 0;
    int m_rej = 0;
    int last_acc = -1000;
    int acc_q[$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", tag, phase, cyc, act, exp);
        end
    endtask

    // One clock: drive after falling edge, compare mid-low phase, advance model
    task automatic step(input bit t, input bit clr);
        int gapv, wcnt;
        bit free, full, gap, win, e_acc;
        @(negedge clk);
        trig_in = t;
        rej_clr = clr;
        #5;
        free  = (m_occ > 0) && (m_tmr == RD - 1);
        full  = (m_occ == DEPTH) && !free;
        gapv  = (int'(min_gap) < 1) ? 1 : int'(min_gap);
        gap   = (cyc - last_acc) < gapv;
        wcnt  = 0;
        foreach (acc_q[i]) if (cyc - acc_q[i] <= int'(win_len)) wcnt++;
        win   = (win_len != 0) && (wcnt >= int'(win_max));
        e_acc = t && !full && !gap && !win;
        chk("R2 accept", int'(accept), int'(e_acc));
        chk("R8 busy", int'(busy), int'(full | gap | win));
        chk("R3 occupancy", int'(occupancy), m_occ);
        chk("R9 rej_count", int'(rej_count), m_rej);
        // advance model to the next cycle
        if (m_occ == 0 || free) m_tmr = 0; else m_tmr++;
        m_occ = m_occ + int'(e_acc) - int'(free);
        if (clr) m_rej = 0;
        else if (t && !e_acc && m_rej < REJ_MAX) m_rej++;
        if (e_acc) begin
            last_acc = cyc;
            acc_q.push_back(cyc);
        end
        while (acc_q.size() > 0 && cyc - acc_q[0] > 70) void'(acc_q.pop_front());
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 60000);
        bad++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1: reset state
        chk("R1 accept", int'(accept), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 rej_count", int'(rej_count), 0);

        // R6: spacing only, continuous trigger
        phase = "R6 spacing gap=4";
        min_gap = 8'd4; win_len = '0;
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
        idle(600);
        phase = "R6 spacing gap=1";
        min_gap = 8'd1;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        idle(600);

        // R3, R5: fill to DEPTH, then accepts only on release cycles; counter saturates
        phase = "R3/R5 fill and release";
        min_gap = 8'd0;
        rej_clr = 1'b0;
        step(1'b0, 1'b1);
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0);
        // R4: drain back-to-back at 36 cycles per event
        phase = "R4 drain";
        idle(DEPTH * RD + 20);
        chk("R4 drained occupancy", int'(occupancy), 0);

        // R9: clear while a trigger is refused in the same cycle
        phase = "R9 clear priority";
        min_gap = 8'd8;
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        idle(40);

        // R7: sliding window limit
        phase = "R7 window 20/3";
        min_gap = 8'd1; win_len = 7'd20; win_max = 7'd3;
        for (int i = 0; i < 100; i++) step(1'b1, 1'b0);
        idle(700);
        phase = "R7 window 64/2";
        win_len = 7'd64; win_max = 7'd2;
        for (int i = 0; i < 150; i++) step(1'b1, 1'b0);
        idle(700);

        // Mixed random stream
        phase = "R2/R8 random mix";
        min_gap = 8'd3; win_len = 7'd40; win_max = 7'd5;
        for (int i = 0; i < 4000; i++)
            step(($urandom % 100) < 35, ($urandom % 200) == 0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule